// File: doc/BRIEF.md
# Per-Register Pipeline Scoreboard

This block keeps one pending-write flag for each architectural register of an in-order pipeline. The register-read stage presents the decoded instruction: two source indices, a destination index, a flag saying whether the instruction writes a register, and a flag marking it as fetched down a mispredicted path. The block answers in the same cycle. It raises `stall` when a source still waits for a value. Otherwise it raises `issue`, and at that clock edge it reserves the destination.

The writeback stage names the register it completes, and that register's flag is released at the same edge. Register 0 is hardwired and is never reserved. An instruction marked as wrong-path is dropped. It neither issues, nor stalls, nor reserves anything. When a reservation and a release meet on one register in one cycle, the reservation is kept.

Top module: `reg_scoreboard`

## Requirements
- R1: Reset clears every busy flag. After reset, no source index causes `stall`.
- R2: When an instruction issues with `rr_writes`=1 and `rr_dst`≠0, the busy flag of `rr_dst` is set at that clock edge. From the next cycle on, reading that register stalls.
- R3: `wb_valid`=1 clears the busy flag of `wb_dst` at the clock edge. Reads of that register stop stalling from the next cycle, not in the same cycle.
- R4: With `rr_valid`=1 and `rr_wrong_path`=0, `stall`=1 exactly when the flag of `rr_src_a` or `rr_src_b` is set. Otherwise `issue`=1. `stall` and `issue` are never high together, and both are 0 when `rr_valid`=0.
- R5: With `rr_wrong_path`=1, both `stall` and `issue` are 0 and no flag is set, whatever the destination.
- R6: A set and a clear aimed at the same register in the same cycle leave the flag set.
- R7: A set and a clear aimed at different registers in the same cycle both take effect.
- R8: Register 0 is never marked busy, and reads of register 0 never stall.
- R9: An instruction with `rr_writes`=0 issues without changing any flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rr_valid | input | 1 | An instruction is at register read |
| rr_src_a | input | 5 | First source register index |
| rr_src_b | input | 5 | Second source register index |
| rr_dst | input | 5 | Destination register index |
| rr_writes | input | 1 | The instruction writes `rr_dst` |
| rr_wrong_path | input | 1 | The instruction is on a discarded path |
| wb_valid | input | 1 | A writeback completes this cycle |
| wb_dst | input | 5 | Register being written back |
| stall | output | 1 | Register read must hold |
| issue | output | 1 | The instruction proceeds and reserves its destination |

## Verification
After reset, the bench probes every register so that any stale flag becomes visible. It then reserves each register in turn and probes all 32, which would expose a decoder aimed at the wrong index. Directed cycles pair a set and a clear on the same register, then on different ones. This separates the two precedence orders and shows whether both updates land. A long pseudo-random run then mixes wrong-path, no-destination, register-0 and writeback traffic against an arithmetic model of the 32 flags.

// File: rtl/reg_scoreboard.sv
module reg_scoreboard #(
  parameter int NREGS = 32,
  localparam int IW = $clog2(NREGS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rr_valid,
  input  logic [IW-1:0] rr_src_a,
  input  logic [IW-1:0] rr_src_b,
  input  logic [IW-1:0] rr_dst,
  input  logic          rr_writes,
  input  logic          rr_wrong_path,
  input  logic          wb_valid,
  input  logic [IW-1:0] wb_dst,
  output logic          stall,
  output logic          issue
);

  logic [NREGS-1:0] busy;
  logic [NREGS-1:0] set_mask, clr_mask;
  logic             live, dep;

  assign live  = rr_valid && !rr_wrong_path;
  assign dep   = busy[rr_src_a] || busy[rr_src_b];
  assign stall = live && dep;
  assign issue = live && !dep;

  always_comb begin
    set_mask = '0;
    clr_mask = '0;
    if (issue && rr_writes && rr_dst != '0) set_mask[rr_dst] = 1'b1;
    if (wb_valid) clr_mask[wb_dst] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) busy <= '0;
    else        busy <= ((busy & ~clr_mask) | set_mask) & ~{{(NREGS-1){1'b0}}, 1'b1};
  end

  AST_R0_NEVER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !busy[0]);                                                                  // R8
  AST_STALL_ISSUE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(stall && issue));                                                         // R4
  AST_FLUSH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    rr_wrong_path |-> !stall && !issue);                                        // R5
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    issue && rr_writes && rr_dst != '0 |=> busy[$past(rr_dst)]);                // R6
  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid && !(issue && rr_writes && rr_dst == wb_dst) |=> !busy[$past(wb_dst)]); // R3
  AST_NOWRITE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wb_valid && !(issue && rr_writes) |=> $stable(busy));                      // R9

endmodule

// File: tb/reg_scoreboard_test.sv
module reg_scoreboard_test;
  logic clk = 0, rst_n = 0;
  logic rr_valid = 0, rr_writes = 0, rr_wrong_path = 0, wb_valid = 0;
  logic [4:0] rr_src_a = 0, rr_src_b = 0, rr_dst = 0, wb_dst = 0;
  logic stall, issue;
  int checks = 0, failures = 0;
  logic [31:0] m = '0;
  logic [31:0] lfsr = 32'hACE1_1234;

  always #2 clk = ~clk;

  reg_scoreboard uut (.*);

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic step(string tag, logic v, logic [4:0] a, logic [4:0] b, logic [4:0] d,
                      logic w, logic f, logic wv, logic [4:0] wd);
    logic es, ei;
    logic [31:0] nm;
    @(negedge clk);
    rr_valid = v; rr_src_a = a; rr_src_b = b; rr_dst = d;
    rr_writes = w; rr_wrong_path = f; wb_valid = wv; wb_dst = wd;
    #1;
    es = v && !f && (m[a] || m[b]);
    ei = v && !f && !es;
    chk({tag, " stall"}, stall, es);
    chk({tag, " issue"}, issue, ei);
    nm = m;
    if (wv) nm[wd] = 1'b0;
    if (ei && w && d != 0) nm[d] = 1'b1;
    @(posedge clk);
    m = nm;
  endtask

  task automatic probe_all(string tag);
    for (int r = 0; r < 32; r++) step(tag, 1, r[4:0], 5'd0, 5'd0, 0, 0, 0, 5'd0);
  endtask

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    probe_all("R1 reset");
    step("R4 idle", 0, 5'd3, 5'd3, 5'd0, 0, 0, 0, 5'd0);
    for (int r = 0; r < 32; r++) begin
      step("R2 set", 1, 5'd0, 5'd0, r[4:0], 1, 0, 0, 5'd0);
      probe_all("R2 R8 probe");
      step("R3 clear", 0, 5'd0, 5'd0, 5'd0, 0, 0, 1, r[4:0]);
      step("R3 next", 1, r[4:0], r[4:0], 5'd0, 0, 0, 0, 5'd0);
    end
    step("R5 flush", 1, 5'd0, 5'd0, 5'd9, 1, 1, 0, 5'd0);
    step("R5 after", 1, 5'd9, 5'd0, 5'd0, 0, 0, 0, 5'd0);
    step("R2 set7", 1, 5'd0, 5'd0, 5'd7, 1, 0, 0, 5'd0);
    step("R3 same-cycle", 1, 5'd7, 5'd1, 5'd0, 0, 0, 1, 5'd7);
    step("R3 released", 1, 5'd7, 5'd1, 5'd0, 0, 0, 0, 5'd0);
    step("R6 set+clr", 1, 5'd0, 5'd0, 5'd5, 1, 0, 1, 5'd5);
    step("R6 kept", 1, 5'd5, 5'd0, 5'd0, 0, 0, 0, 5'd0);
    step("R7 both", 1, 5'd0, 5'd0, 5'd6, 1, 0, 1, 5'd5);
    step("R7 a", 1, 5'd5, 5'd0, 5'd0, 0, 0, 0, 5'd0);
    step("R7 b", 1, 5'd0, 5'd6, 5'd0, 0, 0, 0, 5'd0);
    step("R4 stalled set", 1, 5'd6, 5'd0, 5'd8, 1, 0, 0, 5'd0);
    step("R4 no res", 1, 5'd8, 5'd0, 5'd0, 0, 0, 0, 5'd0);
    step("R9 nodst", 1, 5'd0, 5'd0, 5'd11, 0, 0, 0, 5'd0);
    probe_all("R9 probe");
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      step("R4 R5 R6 R7 R9 mix", lfsr[0] | lfsr[1], lfsr[6:2], lfsr[11:7], lfsr[16:12] & 5'h0F,
           lfsr[17], lfsr[18] & lfsr[19], lfsr[20] | lfsr[21], lfsr[26:22] & 5'h0F);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule